// File: doc/BRIEF.md
# Pipelined Burst SRAM Control Front End

This block holds the synchronous control path of a pipelined static RAM with burst addressing and byte-lane writes. On each rising clock edge it decodes three chip enables and two address strobes. When a strobe arrives while the device is selected, it registers the address. Its two low bits go into a two-bit burst counter, and an active-low advance input steps that counter through the four words of an aligned group. Every edge spent in the selected state is one access to a small internal array at the registered address. That access is a write if either the global write or the byte-write enable is low, and a read otherwise.

A read is registered in the array and appears on the data output one clock after the access edge. The data bus is modelled as separate input, output and output-enable ports. The output enable follows an asynchronous active-low enable input, gated by whether the last access was a read. On the first read that follows a selection made from the deselected state, the output enable is held off for that cycle.

The block is meant to sit behind pads that merge the split bus into one bidirectional bus. Its word width is a parameter, built from nine-bit lanes, and so is the array depth.

Top module: `sbsram_core`

## Requirements
- R1: The device counts as selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0 at the edge. The address is captured only when a strobe is present at that edge and the device is selected.
- R2: A low `adsp_n` counts as a strobe only while `ce1_n` is low. With `ce1_n` high and `adsc_n` high, the state is left unchanged and any burst in progress continues.
- R3: A capture loads `addr[1:0]` into the burst counter. The access address is {registered upper bits, counter}. The counter advances by one, wrapping modulo 4, on each selected edge with `adv_n`=0 and no strobe.
- R4: An access with `gw_n`=0 writes every lane, whatever `bwe_n` and `bw_n` are.
- R5: With `gw_n`=1 and `bwe_n`=0, only the lanes whose `bw_n` bit is 0 are written. Lane i is bits [9i+8:9i]. With `bwe_n`=1, `bw_n` has no effect and the access is a read.
- R6: The read data of an access at edge E is on `dq_out` after edge E and holds until the next read.
- R7: `dq_oe` is high only while `oe_n` is low and the last access edge was a read. It follows `oe_n` without waiting for a clock edge.
- R8: On the first read after a selection made from the deselected state, `dq_oe` stays low for that one output cycle, whatever `oe_n` is.
- R9: A strobe while the device is not selected puts the block into the deselected state. No access happens after that edge, so `dq_oe` is low from the second cycle on.
- R10: After reset the block is deselected and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce1_n | input | 1 | Chip enable, active low; also qualifies `adsp_n` |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | LANES | Per-lane write select, active low |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANES*LANE_W | Write data from the bus |
| dq_out | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | Bus drive enable |

## Verification
A wrong burst counter or a wrongly captured address shows up as wrong data on `dq_out` in the cycle after the read edge that uses it. A lane decode fault shows up on the next read of that word. A stale selection flag or a wrong first-read mask changes `dq_oe` in the very next output cycle, so the bench compares both outputs against its own model on every clock. It uses random strobes, enables and write masks, plus directed wrap, override and deselect sequences.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  typedef enum logic {SEL_OFF = 1'b0, SEL_ON = 1'b1} sel_state_t;
  localparam int BURST_W = 2;
endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              acc,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              fresh,
  output logic              desel_evt
);
  localparam int HI_W = ADDR_W - BURST_W;

  sel_state_t         state_q;
  logic [HI_W-1:0]    base_q;
  logic [BURST_W-1:0] cnt_q;
  logic               fresh_q;
  logic               sel, strb;

  assign sel  = !ce1_n && ce2 && !ce3_n;
  assign strb = (!adsp_n && !ce1_n) || !adsc_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEL_OFF;
      base_q  <= '0;
      cnt_q   <= '0;
      fresh_q <= 1'b0;
    end else begin
      fresh_q <= strb && sel && (state_q == SEL_OFF);
      if (strb && sel) begin
        state_q <= SEL_ON;
        base_q  <= addr[ADDR_W-1:BURST_W];
        cnt_q   <= addr[BURST_W-1:0];
      end else if (strb) begin
        state_q <= SEL_OFF;
      end else if (state_q == SEL_ON && !adv_n) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign acc       = (state_q == SEL_ON);
  assign acc_addr  = {base_q, cnt_q};
  assign fresh     = fresh_q;
  assign desel_evt = strb && !sel;

  // R3: advance steps the counter by one with 2-bit wrap
  a_r3_advance: assert property (@(posedge clk) disable iff (rst)
    (acc && !strb && !adv_n) |=> (cnt_q == $past(cnt_q) + 2'd1));
  // R2: a processor strobe under ce1_n high leaves the captured address alone
  a_r2_adsp_masked: assert property (@(posedge clk) disable iff (rst)
    (!adsp_n && ce1_n && adsc_n) |=> ($stable(base_q) && $stable(state_q)));
endmodule

// File: rtl/sbsram_wdec.sv
module sbsram_wdec #(
  parameter int LANES = 4
) (
  input  logic             acc,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  output logic [LANES-1:0] lane_we,
  output logic             rd_en
);
  logic wr_cyc;

  assign wr_cyc = !gw_n || !bwe_n;

  always_comb begin
    lane_we = '0;
    if (acc) begin
      if (!gw_n)       lane_we = '1;
      else if (!bwe_n) lane_we = ~bw_n;
    end
  end

  assign rd_en = acc && !wr_cyc;
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        lane_we,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       a,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = LANES * LANE_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (lane_we[l]) mem[a][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
    end
    if (rd_en) rd_q <= mem[a];
  end

  assign rdata = rd_q;
endmodule

// File: rtl/sbsram_core.sv
module sbsram_core #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    adsp_n,
  input  logic                    adsc_n,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  logic              acc, fresh, desel_evt, rd_en;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  lane_we;
  logic              rvld_q, mask_q;

  sbsram_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst(rst), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .addr(addr),
    .acc(acc), .acc_addr(acc_addr), .fresh(fresh), .desel_evt(desel_evt)
  );

  sbsram_wdec #(.LANES(LANES)) wdec_i (
    .acc(acc), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .lane_we(lane_we), .rd_en(rd_en)
  );

  sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
    .clk(clk), .lane_we(lane_we), .rd_en(rd_en), .a(acc_addr),
    .wdata(dq_in), .rdata(dq_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rvld_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      rvld_q <= rd_en;
      mask_q <= rd_en && fresh;
    end
  end

  assign dq_oe = rvld_q && !mask_q && !oe_n;

  // R4: global write reaches every lane
  a_r4_global_all: assert property (@(posedge clk) disable iff (rst)
    (acc && !gw_n) |-> (lane_we == '1));
  // R5: without any write enable no lane is written
  a_r5_no_lane: assert property (@(posedge clk) disable iff (rst)
    (gw_n && bwe_n) |-> (lane_we == '0));
  // R8: first read after selection from idle never drives
  a_r8_first_mask: assert property (@(posedge clk) disable iff (rst)
    (fresh && rd_en) |=> !dq_oe);
  // R9: after a deselect the bus is released from the second cycle on
  a_r9_release: assert property (@(posedge clk) disable iff (rst)
    desel_evt |=> ##1 !dq_oe);
endmodule

// File: tb/sbsram_core_tb.sv
module sbsram_core_tb_top;
  localparam int ADDR_W = 6;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n;
  logic [LANES-1:0]  bw_n;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] dq_in, dq_out;
  logic              dq_oe;

  always #2.5 clk = ~clk;

  sbsram_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dut_i (
    .clk(clk), .rst(rst), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .addr(addr), .oe_n(oe_n), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int n_chk = 0;
  int n_bad = 0;
  string cur_tag = "R10";

  logic [WORD_W-1:0] m_mem [DEPTH];
  logic              m_act = 1'b0, m_fresh = 1'b0, m_rvld = 1'b0, m_mask = 1'b0;
  logic [ADDR_W-3:0] m_base = '0;
  logic [1:0]        m_cnt = '0;
  logic [WORD_W-1:0] m_rd = '0;

  task automatic check(input string tag, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Model of one clock edge, from the requirements
  task automatic model_edge();
    logic sel, strb, wr;
    logic [ADDR_W-1:0] a;
    sel  = !ce1_n && ce2 && !ce3_n;
    strb = (!adsp_n && !ce1_n) || !adsc_n;
    wr   = !gw_n || !bwe_n;
    a    = {m_base, m_cnt};
    m_mask = m_act && !wr && m_fresh;
    m_rvld = m_act && !wr;
    if (m_act) begin
      if (wr) begin
        for (int l = 0; l < LANES; l++)
          if (!gw_n || !bw_n[l]) m_mem[a][l*LANE_W +: LANE_W] = dq_in[l*LANE_W +: LANE_W];
      end else m_rd = m_mem[a];
    end
    m_fresh = strb && sel && !m_act;
    if (strb && sel) begin
      m_act = 1'b1; m_base = addr[ADDR_W-1:2]; m_cnt = addr[1:0];
    end else if (strb) m_act = 1'b0;
    else if (m_act && !adv_n) m_cnt = m_cnt + 2'd1;
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(cur_tag, {{(WORD_W-1){1'b0}}, dq_oe}, {{(WORD_W-1){1'b0}}, m_rvld && !m_mask && !oe_n});
    if (m_rvld) check(cur_tag, dq_out, m_rd);
  endtask

  task automatic idle();
    ce1_n = 0; ce2 = 1; ce3_n = 0; adsp_n = 1; adsc_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bw_n = '1; oe_n = 0;
  endtask

  task automatic start(input logic [ADDR_W-1:0] a);
    idle(); adsc_n = 0; addr = a; tick(); adsc_n = 1;
  endtask

  task automatic gwrite(input logic [WORD_W-1:0] d);
    gw_n = 0; dq_in = d; adv_n = 0; tick(); gw_n = 1; adv_n = 1;
  endtask

  initial begin
    #(5 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [WORD_W-1:0] pat;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    idle(); addr = '0; dq_in = '0;
    // fill the array through the normal port so model and design agree
    start('0);
    rst = 1'b0;
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    m_act = 0; m_fresh = 0; m_rvld = 0; m_mask = 0;
    // R10: deselected after reset
    check("R10", {{(WORD_W-1){1'b0}}, dq_oe}, '0);
    cur_tag = "R4";
    for (int b = 0; b < DEPTH / 4; b++) begin
      start(ADDR_W'(b * 4));
      for (int k = 0; k < 4; k++) gwrite(WORD_W'(b * 4 + k) * 36'h1_0001);
    end
    // R4: global write ignores bwe_n and bw_n
    start(6'd8); gw_n = 0; bwe_n = 0; bw_n = 4'b1010; dq_in = 36'h9_ABCD_EF12; tick();
    gw_n = 1; bwe_n = 1; bw_n = '1; tick(); tick();
    check("R4", dq_out, 36'h9_ABCD_EF12);
    // R5: byte write of lanes 0 and 2 only
    cur_tag = "R5";
    start(6'd9); bwe_n = 0; bw_n = 4'b1010; dq_in = 36'hF_FFFF_FFFF; tick();
    bwe_n = 1; bw_n = 4'b0000; tick(); tick();
    pat = WORD_W'(9) * 36'h1_0001;
    pat[0 +: 9] = 9'h1FF; pat[18 +: 9] = 9'h1FF;
    check("R5", dq_out, pat);
    // R3: burst from low bits 3 wraps 3,0,1,2
    cur_tag = "R3";
    start(6'd23); adv_n = 0;
    for (int k = 0; k < 4; k++) tick();
    // R2: processor strobe with ce1_n high is ignored, burst goes on
    cur_tag = "R2";
    start(6'd12); adv_n = 0; tick();
    ce1_n = 1; adsp_n = 0; addr = 6'd40; tick(); tick();
    idle(); adv_n = 0; tick(); tick();
    // R9 and R1: strobe with ce3_n high deselects; nothing drives after
    cur_tag = "R9";
    start(6'd4); tick();
    ce3_n = 1; adsc_n = 0; addr = 6'd30; tick();
    idle(); tick(); tick();
    cur_tag = "R1";
    ce2 = 0; adsc_n = 0; tick(); idle(); tick(); tick();
    // R8: first read from deselected masked, then R7 follows oe_n
    cur_tag = "R8";
    start(6'd33); adv_n = 0; tick(); tick();
    cur_tag = "R7";
    oe_n = 1; tick(); oe_n = 0; #1; check("R7", {{(WORD_W-1){1'b0}}, dq_oe}, 1);
    // R6: random traffic
    cur_tag = "R6";
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      ce1_n = (r < 8); ce2 = !(r > 250); ce3_n = (r == 100);
      adsp_n = ($urandom % 8) != 0; adsc_n = ($urandom % 8) != 0;
      adv_n = ($urandom % 4) == 0; gw_n = ($urandom % 6) != 0;
      bwe_n = ($urandom % 4) != 0; bw_n = LANES'($urandom);
      oe_n = ($urandom % 5) == 0; addr = ADDR_W'($urandom);
      dq_in = {4'($urandom), 32'($urandom)};
      tick();
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule